// File: doc/BRIEF.md
# Handshake Critical-Input Slack Monitor

This block watches the handshake control lines that feed one pipeline stage and records how closely each input event came to holding that stage up. Every rising and every falling transition of a monitored line counts as its own event. The block stamps each event with the value of a free-running cycle counter. When the stage fires, the environment pulses `fire` and gives `fire_mask`, which lists the events that enable the rule that actually fired. The block then selects the locally critical input, which is the enabling event that arrived last.

For every enabling event the block measures the slack: how many cycles earlier it arrived than the critical one. It adds that slack to a per-event sum. It also keeps, for each event, a count of firings that used it and a count of times it was critical, plus one global firing count. Software or a later stage divides the sums by the use counts to get average slack. Only events in the mask of the rule that fired are candidates. A late event that the firing did not need is never blamed. The counters are read through a small index-addressed read port.

Top module: `hs_slack_monitor`

## Requirements
- R1: Line i produces event 2i when its sampled level goes from 0 to 1 and event 2i+1 when it goes from 1 to 0. The event is seen in the same cycle that the new level is presented. The previous sample resets to 0.
- R2: An event stays pending from its arrival until a firing consumes it. If it arrives again while still pending, the newer arrival time replaces the older one.
- R3: On a firing, only events whose `fire_mask` bit is set and that are pending, or arrive in the firing cycle, are eligible. An event outside the mask is never reported as critical. With no eligible event, `crit_valid` stays 0.
- R4: The critical event is the eligible event with the latest arrival. An event arriving in the firing cycle counts as arriving in that cycle. A tie goes to the lowest event index. `crit_valid` pulses high and `crit_idx` holds the index in the cycle after the firing.
- R5: For each eligible event, the slack (critical arrival cycle minus own arrival cycle) is added to that event's slack sum, and its use count increments. This holds for arrival gaps below 2^TS_W cycles.
- R6: The critical event's critical count increments once per firing that has an eligible event.
- R7: `fire_cnt` increments on every accepted firing and holds otherwise.
- R8: A firing clears the pending state of every event in its mask. A masked event that has not arrived again is not eligible at a later firing. Pending events outside the mask are kept.
- R9: All counts and sums saturate at their all-ones value instead of wrapping.
- R10: `clr` zeroes every count and sum, drops all pending events (including ones arriving in that cycle) and clears `crit_valid`. A firing in the same cycle as `clr` is ignored.
- R11: After reset all counts, sums and `crit_valid` are 0 and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics and pending events |
| hs_line | input | N_LINE | Handshake line levels being observed |
| fire | input | 1 | Stage firing strobe |
| fire_mask | input | 2*N_LINE | Events that enable the rule that fired |
| rd_idx | input | clog2(2*N_LINE) | Event index selecting the read port |
| crit_valid | output | 1 | One-cycle pulse: a critical event was found |
| crit_idx | output | clog2(2*N_LINE) | Index of the last critical event |
| fire_cnt | output | CNT_W | Number of firings |
| rd_crit_cnt | output | CNT_W | Critical count of event `rd_idx` |
| rd_use_cnt | output | CNT_W | Use count of event `rd_idx` |
| rd_slack_sum | output | ACC_W | Slack sum of event `rd_idx` |

## Verification
The assertions take `clr` to override `fire` in the same cycle. They also assume `fire_mask` is only meaningful while `fire` is high, and that `rst_n` is released away from a clock edge. The stimulus changes lines, strobes and masks only at falling edges. It refreshes every event well within 2^TS_W cycles, so ages never wrap. It sweeps every non-empty mask against every pair of arrival offsets for the two lines, which drives both counters and slack sums into saturation.

// File: rtl/slkmon_pkg.sv
package slkmon_pkg;

  // Position of an edge event within the pair owned by one line.
  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } edge_pol_e;

  function automatic int unsigned evt_index(input int unsigned line, input edge_pol_e pol);
    return 2 * line + ((pol == POL_FALL) ? 1 : 0);
  endfunction

endpackage

// File: rtl/slkmon_edge.sv
module slkmon_edge
  import slkmon_pkg::*;
#(
  parameter int N_LINE = 2,
  localparam int N_EVT = 2 * N_LINE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINE-1:0] line_i,
  output logic [N_EVT-1:0]  evt_o
);

  logic [N_LINE-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_i;
  end

  for (genvar g = 0; g < N_LINE; g++) begin : g_line
    assign evt_o[evt_index(g, POL_RISE)] =  line_i[g] & ~prev_q[g];
    assign evt_o[evt_index(g, POL_FALL)] = ~line_i[g] &  prev_q[g];
  end

endmodule

// File: rtl/slkmon_stamp.sv
module slkmon_stamp #(
  parameter int N_EVT = 4,
  parameter int TS_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic [N_EVT-1:0]           evt,
  input  logic                       fire,
  input  logic [N_EVT-1:0]           mask,
  output logic [N_EVT-1:0]           elig,
  output logic [N_EVT-1:0][TS_W-1:0] age
);

  logic [TS_W-1:0]            now_q, now_d;
  logic [N_EVT-1:0][TS_W-1:0] ts_q;
  logic [N_EVT-1:0]           pend_q, pend_d;

  // free-running time base
  always_comb now_d = now_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_d;
  end

  // pending state: new arrivals join, consumed and cleared events leave
  always_comb begin
    if (clr) pend_d = '0;
    else     pend_d = (pend_q | evt) & ~(fire ? mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_ts
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ts_q[g] <= '0;
      else if (evt[g]) ts_q[g] <= now_q;
    end
    // a same-cycle arrival has age zero
    assign age[g] = (pend_q[g] && !evt[g]) ? (now_q - ts_q[g]) : '0;
  end

  assign elig = {N_EVT{fire}} & mask & (pend_q | evt);

  assert_consumed_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((pend_q & $past(mask)) == '0))
    else $error("masked event still pending after firing");

endmodule

// File: rtl/slkmon_pick.sv
module slkmon_pick #(
  parameter int N_EVT = 4,
  parameter int TS_W  = 16,
  parameter int IDX_W = 2
) (
  input  logic [N_EVT-1:0]           elig,
  input  logic [N_EVT-1:0][TS_W-1:0] age,
  output logic                       any,
  output logic [IDX_W-1:0]           crit_idx,
  output logic [N_EVT-1:0][TS_W-1:0] slack
);

  logic [TS_W-1:0] best;

  // youngest eligible event wins; strict compare keeps the lowest index on ties
  always_comb begin
    any      = 1'b0;
    best     = '0;
    crit_idx = '0;
    for (int i = 0; i < N_EVT; i++) begin
      if (elig[i] && (!any || age[i] < best)) begin
        any      = 1'b1;
        best     = age[i];
        crit_idx = IDX_W'(i);
      end
    end
    for (int i = 0; i < N_EVT; i++) begin
      slack[i] = elig[i] ? (age[i] - best) : '0;
    end
  end

endmodule

// File: rtl/slkmon_accum.sv
module slkmon_accum #(
  parameter int N_EVT = 4,
  parameter int TS_W  = 16,
  parameter int IDX_W = 2,
  parameter int CNT_W = 16,
  parameter int ACC_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       fire,
  input  logic [N_EVT-1:0]           elig,
  input  logic                       any,
  input  logic [IDX_W-1:0]           crit_idx,
  input  logic [N_EVT-1:0][TS_W-1:0] slack,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [CNT_W-1:0]           fire_cnt,
  output logic [CNT_W-1:0]           rd_crit_cnt,
  output logic [CNT_W-1:0]           rd_use_cnt,
  output logic [ACC_W-1:0]           rd_slack_sum
);

  localparam int SUM_W = ((ACC_W > TS_W) ? ACC_W : TS_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [N_EVT-1:0][CNT_W-1:0] crit_arr;
  logic [N_EVT-1:0][CNT_W-1:0] use_arr;
  logic [N_EVT-1:0][ACC_W-1:0] sum_arr;

  // global firing counter
  logic [CNT_W-1:0] fcnt_q, fcnt_d;
  logic             fcnt_en;

  always_comb begin
    fcnt_en = clr | fire;
    if (clr)                   fcnt_d = '0;
    else if (fcnt_q != CNT_MAX) fcnt_d = fcnt_q + 1'b1;
    else                       fcnt_d = fcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fcnt_q <= '0;
    else if (fcnt_en) fcnt_q <= fcnt_d;
  end

  assign fire_cnt = fcnt_q;

  // per-event statistics
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    logic [CNT_W-1:0] crit_q, crit_d, use_q, use_d;
    logic [ACC_W-1:0] sum_q, sum_d;
    logic [SUM_W-1:0] sum_wide;
    logic             en;

    always_comb begin
      en       = clr | (fire & elig[g]);
      crit_d   = crit_q;
      use_d    = use_q;
      sum_d    = sum_q;
      sum_wide = SUM_W'(sum_q) + SUM_W'(slack[g]);
      if (clr) begin
        crit_d = '0;
        use_d  = '0;
        sum_d  = '0;
      end else if (fire && elig[g]) begin
        if (use_q != CNT_MAX) use_d = use_q + 1'b1;
        sum_d = (sum_wide > SUM_W'(ACC_MAX)) ? ACC_MAX : sum_wide[ACC_W-1:0];
        if (any && crit_idx == IDX_W'(g) && crit_q != CNT_MAX) crit_d = crit_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        crit_q <= '0;
        use_q  <= '0;
        sum_q  <= '0;
      end else if (en) begin
        crit_q <= crit_d;
        use_q  <= use_d;
        sum_q  <= sum_d;
      end
    end

    assign crit_arr[g] = crit_q;
    assign use_arr[g]  = use_q;
    assign sum_arr[g]  = sum_q;
  end

  // read port
  always_comb begin
    rd_crit_cnt  = '0;
    rd_use_cnt   = '0;
    rd_slack_sum = '0;
    if (32'(rd_idx) < N_EVT) begin
      rd_crit_cnt  = crit_arr[rd_idx];
      rd_use_cnt   = use_arr[rd_idx];
      rd_slack_sum = sum_arr[rd_idx];
    end
  end

  assert_clr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fire_cnt == '0))
    else $error("firing count not cleared");

  assert_fire_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_cnt == CNT_MAX && !clr) |=> (fire_cnt == CNT_MAX))
    else $error("firing count wrapped");

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(fire_cnt))
    else $error("firing count moved without a firing");

endmodule

// File: rtl/hs_slack_monitor.sv
module hs_slack_monitor #(
  parameter int N_LINE = 2,
  parameter int TS_W   = 16,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 24,
  localparam int N_EVT = 2 * N_LINE,
  localparam int IDX_W = $clog2(N_EVT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N_LINE-1:0] hs_line,
  input  logic              fire,
  input  logic [N_EVT-1:0]  fire_mask,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              crit_valid,
  output logic [IDX_W-1:0]  crit_idx,
  output logic [CNT_W-1:0]  fire_cnt,
  output logic [CNT_W-1:0]  rd_crit_cnt,
  output logic [CNT_W-1:0]  rd_use_cnt,
  output logic [ACC_W-1:0]  rd_slack_sum
);

  logic                       fire_eff;
  logic [N_EVT-1:0]           evt;
  logic [N_EVT-1:0]           elig;
  logic [N_EVT-1:0][TS_W-1:0] age;
  logic [N_EVT-1:0][TS_W-1:0] slack;
  logic                       any;
  logic [IDX_W-1:0]           pick_idx;

  // clear wins over a firing in the same cycle
  assign fire_eff = fire & ~clr;

  slkmon_edge #(.N_LINE(N_LINE)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (hs_line),
    .evt_o  (evt)
  );

  slkmon_stamp #(.N_EVT(N_EVT), .TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .evt   (evt),
    .fire  (fire_eff),
    .mask  (fire_mask),
    .elig  (elig),
    .age   (age)
  );

  slkmon_pick #(.N_EVT(N_EVT), .TS_W(TS_W), .IDX_W(IDX_W)) u_pick (
    .elig     (elig),
    .age      (age),
    .any      (any),
    .crit_idx (pick_idx),
    .slack    (slack)
  );

  slkmon_accum #(
    .N_EVT(N_EVT), .TS_W(TS_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .fire         (fire_eff),
    .elig         (elig),
    .any          (any),
    .crit_idx     (pick_idx),
    .slack        (slack),
    .rd_idx       (rd_idx),
    .fire_cnt     (fire_cnt),
    .rd_crit_cnt  (rd_crit_cnt),
    .rd_use_cnt   (rd_use_cnt),
    .rd_slack_sum (rd_slack_sum)
  );

  // critical-event report register
  logic             cv_q, cv_d;
  logic [IDX_W-1:0] ci_q, ci_d;
  logic             ci_en;

  always_comb begin
    cv_d  = fire_eff & any;
    ci_en = clr | (fire_eff & any);
    ci_d  = clr ? '0 : pick_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b0;
      ci_q <= '0;
    end else begin
      cv_q <= cv_d;
      if (ci_en) ci_q <= ci_d;
    end
  end

  assign crit_valid = cv_q;
  assign crit_idx   = ci_q;

  assert_crit_after_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> $past(fire && !clr))
    else $error("critical report without an accepted firing");

  assert_crit_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> ((($past(fire_mask) >> crit_idx) & N_EVT'(1)) != '0))
    else $error("critical event outside the firing mask");

endmodule

// File: tb/hs_slack_monitor_test.sv
module hs_slack_monitor_test;
  localparam int NL = 2, NE = 4, IW = 2, TW = 8, CW = 6, AW = 8;
  localparam int CMAX = 63, AMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr = 1'b0, fire = 1'b0;
  logic [NL-1:0] hs_line = '0;
  logic [NE-1:0] fire_mask = '0;
  logic [IW-1:0] rd_idx = '0;
  logic crit_valid;
  logic [IW-1:0] crit_idx;
  logic [CW-1:0] fire_cnt, rd_crit_cnt, rd_use_cnt;
  logic [AW-1:0] rd_slack_sum;

  always #10 clk = ~clk;

  hs_slack_monitor #(.N_LINE(NL), .TS_W(TW), .CNT_W(CW), .ACC_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hs_line(hs_line), .fire(fire),
    .fire_mask(fire_mask), .rd_idx(rd_idx), .crit_valid(crit_valid),
    .crit_idx(crit_idx), .fire_cnt(fire_cnt), .rd_crit_cnt(rd_crit_cnt),
    .rd_use_cnt(rd_use_cnt), .rd_slack_sum(rd_slack_sum)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [NL-1:0] m_line = '0;
  logic [NE-1:0] m_pend = '0;
  int m_ts[NE], m_crit[NE], m_use[NE], m_sum[NE];
  int m_fire = 0;
  bit exp_cv = 1'b0;
  int exp_ci = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // drive one cycle and advance the arithmetic expectation
  task automatic step(logic [NL-1:0] ln, bit f, logic [NE-1:0] mk, bit c);
    logic [NE-1:0] ev, el;
    int latest, ci, t;
    @(negedge clk);
    hs_line = ln; fire = f; fire_mask = mk; clr = c;
    for (int i = 0; i < NL; i++) begin
      ev[2*i]   = ln[i] & ~m_line[i];
      ev[2*i+1] = ~ln[i] & m_line[i];
    end
    m_line = ln;
    if (c) begin
      for (int i = 0; i < NE; i++) begin
        m_crit[i] = 0; m_use[i] = 0; m_sum[i] = 0;
      end
      m_fire = 0; m_pend = '0; exp_cv = 1'b0;
    end else begin
      if (f) begin
        el = mk & (m_pend | ev);
        latest = -1; ci = 0;
        for (int i = 0; i < NE; i++) begin
          if (el[i]) begin
            t = ev[i] ? cyc : m_ts[i];
            if (t > latest) begin latest = t; ci = i; end
          end
        end
        for (int i = 0; i < NE; i++) begin
          if (el[i]) begin
            t = ev[i] ? cyc : m_ts[i];
            m_sum[i] = (m_sum[i] + latest - t > AMAX) ? AMAX : m_sum[i] + latest - t;
            if (m_use[i] < CMAX) m_use[i]++;
          end
        end
        if (el != '0 && m_crit[ci] < CMAX) m_crit[ci]++;
        if (m_fire < CMAX) m_fire++;
        exp_cv = (el != '0);
        if (exp_cv) exp_ci = ci;
      end else begin
        exp_cv = 1'b0;
      end
      for (int i = 0; i < NE; i++) if (ev[i]) m_ts[i] = cyc;
      m_pend = (m_pend | ev) & ~(f ? mk : '0);
    end
    cyc++;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(m_line, 1'b0, '0, 1'b0);
  endtask

  task automatic rd(int idx);
    rd_idx = IW'(idx);
    #1;
  endtask

  task automatic chk_model(string req);
    check({req, " crit_valid"}, int'(crit_valid), int'(exp_cv));
    if (exp_cv) check({req, " crit_idx"}, int'(crit_idx), exp_ci);
    check({req, " fire_cnt"}, int'(fire_cnt), m_fire);
    for (int i = 0; i < NE; i++) begin
      rd(i);
      check($sformatf("%s crit_cnt[%0d]", req, i), int'(rd_crit_cnt), m_crit[i]);
      check($sformatf("%s use_cnt[%0d]", req, i), int'(rd_use_cnt), m_use[i]);
      check($sformatf("%s slack_sum[%0d]", req, i), int'(rd_slack_sum), m_sum[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_ts[i] = 0; m_crit[i] = 0; m_use[i] = 0; m_sum[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk_model("R11");

    // R1/R4/R5/R6: rise of line 0 (event 0) then rise of line 1 (event 2) two cycles later
    step(2'b01, 1'b0, '0, 1'b0);
    idle(1);
    step(2'b11, 1'b0, '0, 1'b0);
    step(2'b11, 1'b1, 4'b0101, 1'b0);
    check("R1 rise event seen", int'(crit_valid), 1);
    check("R4 latest arrival", int'(crit_idx), 2);
    rd(0); check("R5 slack of early event", int'(rd_slack_sum), 2);
    rd(2); check("R6 critical count", int'(rd_crit_cnt), 1);
    chk_model("R5");

    // R3: falls give events 1 and 3; event 3 arrives last but is not in the mask
    step(2'b10, 1'b0, '0, 1'b0);
    idle(2);
    step(2'b00, 1'b0, '0, 1'b0);
    step(2'b00, 1'b1, 4'b0010, 1'b0);
    check("R3 masked-out late event not blamed", int'(crit_idx), 1);
    rd(3); check("R3 unmasked critical count", int'(rd_crit_cnt), 0);
    chk_model("R3");

    // R4 tie: both lines rise in one cycle
    step(2'b11, 1'b0, '0, 1'b0);
    step(2'b11, 1'b1, 4'b0101, 1'b0);
    check("R4 tie lowest index", int'(crit_idx), 0);

    // R8: consumed events are not reused
    step(2'b11, 1'b1, 4'b0101, 1'b0);
    check("R8 stale events not eligible", int'(crit_valid), 0);
    check("R7 firing count", int'(fire_cnt), 4);
    chk_model("R8");

    // R2: event 1 re-arrives after event 0; newer time counts
    step(2'b10, 1'b0, '0, 1'b0);
    step(2'b11, 1'b0, '0, 1'b0);
    step(2'b10, 1'b0, '0, 1'b0);
    step(2'b10, 1'b1, 4'b0011, 1'b0);
    check("R2 newer arrival is critical", int'(crit_idx), 1);
    chk_model("R2");

    // R4: arrival in the firing cycle
    step(2'b00, 1'b1, 4'b1000, 1'b0);
    check("R4 same-cycle arrival valid", int'(crit_valid), 1);
    check("R4 same-cycle arrival index", int'(crit_idx), 3);
    chk_model("R4");

    // R10: clear beats a firing and drops a same-cycle arrival
    step(2'b01, 1'b1, 4'b0001, 1'b1);
    check("R10 cleared firing count", int'(fire_cnt), 0);
    check("R10 no report", int'(crit_valid), 0);
    chk_model("R10");
    step(2'b01, 1'b1, 4'b0001, 1'b0);
    check("R10 dropped arrival not eligible", int'(crit_valid), 0);
    chk_model("R10 after");

    // sweep: every mask against every pair of arrival offsets
    step(m_line, 1'b0, '0, 1'b1);
    for (int mk = 1; mk < 16; mk++) begin
      for (int d0 = 0; d0 < 4; d0++) begin
        for (int d1 = 0; d1 < 4; d1++) begin
          for (int k = 0; k < 4; k++) begin
            logic [NL-1:0] ln;
            ln = m_line;
            if (k == d0) ln[0] = ~ln[0];
            if (k == d1) ln[1] = ~ln[1];
            step(ln, 1'b0, '0, 1'b0);
          end
          step(m_line, 1'b1, NE'(mk), 1'b0);
          chk_model("R5 sweep");
        end
      end
    end
    check("R9 firing count saturated", int'(fire_cnt), CMAX);
    chk_model("R9");

    finish_up();
  end

endmodule